// File: doc/BRIEF.md
# Pipelined Segment Access Tree

This block connects one 64-bit word port, driven from the register file side, to a large array of 64-bit state segments held inside the block. A request carries a segment index, read and write strobes, a chain-select bit and write data. It travels down a registered tree. Each tree level decodes a slice of the index and passes the request to exactly one child node. At the bottom, the addressed segment is read, written, or both. The read word comes back on a single output with a valid strobe, after a fixed number of cycles. One request may enter on every cycle, and requests complete in the order they were issued.

The default geometry is the direct configuration. It has 512 segments of 64 bits (32K state bits), a root node, and then 2, 8, 32 and 128 nodes on levels 1 to 4. Each level-4 node feeds four segments. A hybrid geometry is selected by parameters. It has 64 segments, 4 level-1 nodes and 16 level-2 nodes. In this geometry each segment holds a directly addressed 64-bit word plus a 448-bit serial chain of seven 64-bit words. The chain is reached one word per access: each access reads the word at the head and rotates the chain by one word.

Top module: `seg_access_tree`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are low and every segment word and chain word reads as zero.
- R2: A read returns its data on `rd_valid`/`rd_data` exactly L cycles after the request was sampled, where L is the number of node levels plus one: 6 for the direct geometry and 4 for the hybrid geometry. `rd_valid` is high for one cycle per read.
- R3: A write to segment i changes only segment i. Every other segment, including those whose low index bits match i, keeps its value.
- R4: When read and write are asserted together, the read returns the content held before the write, and the new data is stored.
- R5: Requests are accepted on every cycle and complete in issue order. A read issued in the cycle after a write to the same segment returns the new value.
- R6: An index of `NUM_SEG` or above is ignored. A write changes no segment, and a read returns zero with `rd_valid` still high.
- R7: `rd_data` is zero in every cycle in which `rd_valid` is low, including the cycles that complete a write-only request.
- R8: In the hybrid geometry with `acc_chain` low, each of the 64 segments behaves as one directly addressed 64-bit word.
- R9: In the hybrid geometry with `acc_chain` high, an access returns the chain head word (if reading) and shifts the chain by one word. The word entering the tail is `acc_wdata` on a write and the old head otherwise. Seven plain reads therefore return the chain in order and restore it. Chain accesses leave the segment's direct word unchanged.
- R10: In the direct geometry `acc_chain` has no effect, and accesses with it high behave exactly like direct word accesses.
- R11: Every in-range segment index is reachable. For an in-range request, at most one node per level, and one segment, holds the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe for this cycle's request |
| acc_wr | input | 1 | Write strobe for this cycle's request |
| acc_chain | input | 1 | Selects the serial chain portion (hybrid geometry only) |
| acc_idx | input | 10 | Segment index; values of `NUM_SEG` and above are out of range |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | One-cycle strobe marking returned read data |
| rd_data | output | 64 | Returned read data |

## Verification
The bench drives the direct geometry and the hybrid geometry side by side. It compares both against a behavioural model on every cycle, so a pipeline that is one stage too short or too long shows up as data arriving in the wrong cycle. Out-of-range indices 512 and 1023 are written and then segment 0 and segment 511 are read back. A decoder that drops the upper index bits would alias those writes onto real segments. Segments that share low index bits with the written one are read back to catch a decoder that compares only part of the index. A read and write in the same cycle must return the old content; a design that forwards write data would return the new word there. For the chain, the bench loads seven words and reads them twice over: a chain that does not rotate the head back to the tail would return zeros on the second pass, and one that shifts the wrong way would return the words out of order.

// File: rtl/seg_tree_pkg.sv
package seg_tree_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned IDX_W  = 10;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // One request as it travels down the tree
    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  chain;
        idx_t  idx;
        word_t wdata;
    } req_t;

    // Node count on tree level lvl (level 0 is the root)
    function automatic int unsigned level_nodes(int unsigned lvl, int unsigned root_fan,
                                                int unsigned fan);
        int unsigned n;
        n = 1;
        for (int unsigned j = 1; j <= lvl; j++) begin
            n = (j == 1) ? root_fan : n * fan;
        end
        return n;
    endfunction

    // Offset of level lvl inside a flat vector holding every node of the tree
    function automatic int unsigned level_base(int unsigned lvl, int unsigned root_fan,
                                               int unsigned fan);
        int unsigned b;
        b = 0;
        for (int unsigned j = 0; j < lvl; j++) begin
            b = b + level_nodes(j, root_fan, fan);
        end
        return b;
    endfunction

    // Levels below the root, such that the last level times fan gives segs
    function automatic int unsigned tree_depth(int unsigned segs, int unsigned root_fan,
                                               int unsigned fan);
        int unsigned d;
        int unsigned cnt;
        d   = 1;
        cnt = root_fan;
        while (cnt * fan < segs) begin
            cnt = cnt * fan;
            d   = d + 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/seg_tree_level.sv
module seg_tree_level
    import seg_tree_pkg::*;
#(
    parameter int unsigned NODES     = 2,
    parameter int unsigned PARENTS   = 1,
    parameter int unsigned SPAN_LOG2 = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  req_t               up_req,
    input  logic [PARENTS-1:0] up_hit,
    output req_t               dn_req,
    output logic [NODES-1:0]   dn_hit
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned RATIO = NODES / PARENTS;

    typedef struct packed {
        req_t             req;
        logic [NODES-1:0] hit;
    } lvl_t;

    lvl_t st_d, st_q;

    // Shared payload register per level; one hit flop per node
    always_comb begin
        st_d.req = up_req;
        st_d.hit = '0;
        for (int n = 0; n < int'(NODES); n++) begin
            st_d.hit[n] = up_hit[n / int'(RATIO)] &&
                          ((up_req.idx >> SPAN_LOG2) == idx_t'(n));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dn_req = st_q.req;
    assign dn_hit = st_q.hit;

    AST_ONE_NODE_PER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_hit)); // R11

    AST_HIT_NEEDS_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_hit) |-> $past(|up_hit)); // R11

endmodule

// File: rtl/seg_tree_store.sv
module seg_tree_store
    import seg_tree_pkg::*;
#(
    parameter int unsigned NUM_SEG     = 512,
    parameter int unsigned FAN         = 4,
    parameter int unsigned CHAIN_WORDS = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  req_t                      req,
    input  logic [NUM_SEG/FAN-1:0]    hit,
    output logic                      rvalid,
    output word_t                     rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned CW      = (CHAIN_WORDS != 0) ? CHAIN_WORDS : 1;
    localparam int unsigned CH_SEGS = (CHAIN_WORDS != 0) ? NUM_SEG : 1;

    typedef struct packed {
        word_t [NUM_SEG-1:0]          seg;
        word_t [CH_SEGS-1:0][CW-1:0]  chn;
        logic                         rvalid;
        word_t                        rdata;
    } st_t;

    st_t                st_d, st_q;
    logic [NUM_SEG-1:0] seg_hit;
    logic               use_chain;

    assign use_chain = (CHAIN_WORDS != 0) && req.chain;

    // Leaf decode below the last node level
    always_comb begin
        for (int s = 0; s < int'(NUM_SEG); s++) begin
            seg_hit[s] = hit[s / int'(FAN)] && (req.idx == idx_t'(s));
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req.rd;
        st_d.rdata  = '0;
        // Direct word of each segment
        for (int s = 0; s < int'(NUM_SEG); s++) begin
            if (seg_hit[s] && !use_chain) begin
                if (req.rd) st_d.rdata  = st_q.seg[s];
                if (req.wr) st_d.seg[s] = req.wdata;
            end
        end
        // Serial chain: read head, shift by one word, refill the tail
        for (int s = 0; s < int'(CH_SEGS); s++) begin
            if (seg_hit[s] && use_chain && (req.rd || req.wr)) begin
                if (req.rd) st_d.rdata = st_q.chn[s][0];
                for (int w = 0; w < int'(CW) - 1; w++) begin
                    st_d.chn[s][w] = st_q.chn[s][w+1];
                end
                st_d.chn[s][CW-1] = req.wr ? req.wdata : st_q.chn[s][0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;

    AST_OUT_OF_RANGE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req.idx) >= int'(NUM_SEG)) |-> (hit == '0)); // R6

    AST_ONE_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_hit)); // R11

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0)); // R7

    AST_WRITE_ONLY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr && !req.rd) |=> !rvalid); // R7

endmodule

// File: rtl/seg_access_tree.sv
module seg_access_tree
    import seg_tree_pkg::*;
#(
    parameter int unsigned NUM_SEG     = 512,
    parameter int unsigned ROOT_FAN    = 2,
    parameter int unsigned FAN         = 4,
    parameter int unsigned CHAIN_WORDS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              acc_chain,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned DEPTH     = tree_depth(NUM_SEG, ROOT_FAN, FAN);
    localparam int unsigned TOTAL     = level_base(DEPTH + 1, ROOT_FAN, FAN);
    localparam int unsigned LEAF_BASE = level_base(DEPTH, ROOT_FAN, FAN);
    localparam int unsigned LEAF_PAR  = NUM_SEG / FAN;

    req_t             lvl_req [DEPTH+2];
    logic [TOTAL-1:0] all_hit;

    assign lvl_req[0] = '{rd: acc_rd, wr: acc_wr, chain: acc_chain,
                          idx: acc_idx, wdata: acc_wdata};

    for (genvar k = 0; k <= int'(DEPTH); k++) begin : g_level
        localparam int unsigned NODES   = level_nodes(k, ROOT_FAN, FAN);
        localparam int unsigned PARENTS = level_nodes((k == 0) ? 0 : k - 1, ROOT_FAN, FAN);
        localparam int unsigned BASE    = level_base(k, ROOT_FAN, FAN);
        localparam int unsigned PBASE   = level_base((k == 0) ? 0 : k - 1, ROOT_FAN, FAN);

        logic [PARENTS-1:0] up_hit;

        if (k == 0) begin : g_root
            assign up_hit = acc_rd | acc_wr;
        end else begin : g_inner
            assign up_hit = all_hit[PBASE +: PARENTS];
        end

        seg_tree_level #(
            .NODES     (NODES),
            .PARENTS   (PARENTS),
            .SPAN_LOG2 ($clog2(NUM_SEG / NODES))
        ) u_level (
            .clk    (clk),
            .rst_n  (rst_n),
            .up_req (lvl_req[k]),
            .up_hit (up_hit),
            .dn_req (lvl_req[k+1]),
            .dn_hit (all_hit[BASE +: NODES])
        );
    end

    seg_tree_store #(
        .NUM_SEG     (NUM_SEG),
        .FAN         (FAN),
        .CHAIN_WORDS (CHAIN_WORDS)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (lvl_req[DEPTH+1]),
        .hit    (all_hit[LEAF_BASE +: LEAF_PAR]),
        .rvalid (rd_valid),
        .rdata  (rd_data)
    );

endmodule

// File: tb/tb_seg_access_tree.sv
module tb_seg_access_tree;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT_D  = 6;
    localparam int LAT_H  = 4;
    localparam int NSEG_D = 512;
    localparam int NSEG_H = 64;
    localparam int CHW    = 7;

    typedef struct {
        logic        rd;
        logic        wr;
        logic        chain;
        int          idx;
        logic [63:0] wdata;
        string       tag;
    } op_t;

    typedef struct {
        logic        v;
        logic [63:0] d;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;

    logic        d_rd, d_wr, d_chain, h_rd, h_wr, h_chain;
    logic [9:0]  d_idx, h_idx;
    logic [63:0] d_wdata, h_wdata, d_rdata, h_rdata;
    logic        d_rvalid, h_rvalid;

    seg_access_tree dut (
        .clk(clk), .rst_n(rst_n), .acc_rd(d_rd), .acc_wr(d_wr), .acc_chain(d_chain),
        .acc_idx(d_idx), .acc_wdata(d_wdata), .rd_valid(d_rvalid), .rd_data(d_rdata));

    seg_access_tree #(.NUM_SEG(64), .ROOT_FAN(4), .FAN(4), .CHAIN_WORDS(7)) dut_hyb (
        .clk(clk), .rst_n(rst_n), .acc_rd(h_rd), .acc_wr(h_wr), .acc_chain(h_chain),
        .acc_idx(h_idx), .acc_wdata(h_wdata), .rd_valid(h_rvalid), .rd_data(h_rdata));

    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;

    exp_t        qd[$];
    exp_t        qh[$];
    logic [63:0] md [NSEG_D];
    logic [63:0] mh [NSEG_H];
    logic [63:0] mc [NSEG_H][CHW];

    function automatic op_t mk(logic rd, logic wr, logic ch, int idx, logic [63:0] wd, string tag);
        op_t o;
        o.rd = rd; o.wr = wr; o.chain = ch; o.idx = idx; o.wdata = wd; o.tag = tag;
        return o;
    endfunction

    function automatic logic [63:0] pat(int i, int salt);
        return {32'(salt), 32'(i) ^ 32'h5A5A_0F0F};
    endfunction

    function automatic exp_t model_d(op_t o);
        exp_t e;
        e.v = o.rd; e.d = '0; e.tag = o.tag;
        if (o.idx < NSEG_D) begin
            if (o.rd) e.d = md[o.idx];
            if (o.wr) md[o.idx] = o.wdata;
        end
        return e;
    endfunction

    function automatic exp_t model_h(op_t o);
        exp_t        e;
        logic [63:0] head;
        e.v = o.rd; e.d = '0; e.tag = o.tag;
        if (o.idx < NSEG_H) begin
            if (o.chain) begin
                if (o.rd || o.wr) begin
                    head = mc[o.idx][0];
                    if (o.rd) e.d = head;
                    for (int w = 0; w < CHW - 1; w++) mc[o.idx][w] = mc[o.idx][w+1];
                    mc[o.idx][CHW-1] = o.wr ? o.wdata : head;
                end
            end else begin
                if (o.rd) e.d = mh[o.idx];
                if (o.wr) mh[o.idx] = o.wdata;
            end
        end
        return e;
    endfunction

    task automatic compare(string who, exp_t e, logic v, logic [63:0] d);
        checks++;
        if (v !== e.v) begin
            errors++;
            $display("FAIL %s %s rd_valid actual %0b expected %0b", e.tag, who, v, e.v);
        end
        checks++;
        if (d !== e.d) begin
            errors++;
            $display("FAIL %s %s rd_data actual %h expected %h", e.tag, who, d, e.d);
        end
    endtask

    // One clock: check this cycle's outputs, then drive the next request pair
    task automatic cycle(op_t a, op_t b);
        exp_t ed, eh;
        @(negedge clk);
        ed = qd.pop_front();
        eh = qh.pop_front();
        compare("direct", ed, d_rvalid, d_rdata);
        compare("hybrid", eh, h_rvalid, h_rdata);
        d_rd = a.rd; d_wr = a.wr; d_chain = a.chain; d_idx = 10'(a.idx); d_wdata = a.wdata;
        h_rd = b.rd; h_wr = b.wr; h_chain = b.chain; h_idx = 10'(b.idx); h_wdata = b.wdata;
        qd.push_back(model_d(a));
        qh.push_back(model_h(b));
    endtask

    function automatic op_t idle();
        return mk(1'b0, 1'b0, 1'b0, 0, 64'd0, "R7");
    endfunction

    task automatic dop(op_t a); cycle(a, idle()); endtask
    task automatic hop(op_t b); cycle(idle(), b); endtask

    task automatic flush();
        for (int i = 0; i < LAT_D + 1; i++) cycle(idle(), idle());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t z;
        rst_n = 1'b0;
        d_rd = 0; d_wr = 0; d_chain = 0; d_idx = '0; d_wdata = '0;
        h_rd = 0; h_wr = 0; h_chain = 0; h_idx = '0; h_wdata = '0;
        for (int i = 0; i < NSEG_D; i++) md[i] = '0;
        for (int i = 0; i < NSEG_H; i++) begin
            mh[i] = '0;
            for (int w = 0; w < CHW; w++) mc[i][w] = '0;
        end
        repeat (4) @(negedge clk);
        z.v = 1'b0; z.d = '0; z.tag = "R1";
        compare("direct", z, d_rvalid, d_rdata);
        compare("hybrid", z, h_rvalid, h_rdata);
        rst_n = 1'b1;
        for (int i = 0; i < LAT_D; i++) qd.push_back(z);
        for (int i = 0; i < LAT_H; i++) qh.push_back(z);

        // R1: fresh state reads zero in both geometries
        dop(mk(1, 0, 0, 0, 64'd0, "R1"));
        dop(mk(1, 0, 0, 511, 64'd0, "R1"));
        hop(mk(1, 0, 0, 63, 64'd0, "R1"));
        hop(mk(1, 0, 1, 9, 64'd0, "R1"));
        flush();

        // R2: isolated write and read with idle gaps, exact latency
        dop(mk(0, 1, 0, 77, pat(77, 2), "R7"));
        flush();
        dop(mk(1, 0, 0, 77, 64'd0, "R2"));
        flush();
        hop(mk(0, 1, 0, 11, pat(11, 2), "R7"));
        flush();
        hop(mk(1, 0, 0, 11, 64'd0, "R2"));
        flush();

        // R11: every segment reachable, back-to-back
        for (int i = 0; i < NSEG_D; i++) dop(mk(0, 1, 0, i, pat(i, 11), "R7"));
        for (int i = 0; i < NSEG_D; i++) dop(mk(1, 0, 0, i, 64'd0, "R11"));
        flush();

        // R3: single write, neighbours and low-bit aliases unchanged
        dop(mk(0, 1, 0, 37, 64'hDEAD_BEEF_0000_0037, "R3"));
        dop(mk(1, 0, 0, 36, 64'd0, "R3"));
        dop(mk(1, 0, 0, 37, 64'd0, "R3"));
        dop(mk(1, 0, 0, 38, 64'd0, "R3"));
        dop(mk(1, 0, 0, 165, 64'd0, "R3"));
        dop(mk(1, 0, 0, 293, 64'd0, "R3"));
        dop(mk(1, 0, 0, 421, 64'd0, "R3"));
        flush();

        // R4: read and write together return the old word
        dop(mk(1, 1, 0, 100, 64'h1111_2222_3333_4444, "R4"));
        dop(mk(1, 0, 0, 100, 64'd0, "R4"));
        flush();

        // R5: read right after write, interleaved ordering
        dop(mk(0, 1, 0, 300, 64'hCAFE_0000_0000_0300, "R5"));
        dop(mk(1, 0, 0, 300, 64'd0, "R5"));
        dop(mk(0, 1, 0, 301, 64'hCAFE_0000_0000_0301, "R5"));
        dop(mk(1, 0, 0, 299, 64'd0, "R5"));
        dop(mk(1, 0, 0, 301, 64'd0, "R5"));
        flush();

        // R6: out-of-range index ignored, read returns zero with valid
        dop(mk(0, 1, 0, 512, 64'hBAD0_BAD0_BAD0_0512, "R6"));
        dop(mk(0, 1, 0, 1023, 64'hBAD0_BAD0_BAD0_1023, "R6"));
        dop(mk(1, 0, 0, 512, 64'd0, "R6"));
        dop(mk(1, 1, 0, 700, 64'hBAD0_0000_0000_0700, "R6"));
        dop(mk(1, 0, 0, 0, 64'd0, "R6"));
        dop(mk(1, 0, 0, 511, 64'd0, "R6"));
        dop(mk(1, 0, 0, 188, 64'd0, "R6"));
        hop(mk(0, 1, 0, 64, 64'hBAD0_0000_0000_0064, "R6"));
        hop(mk(0, 1, 1, 64, 64'hBAD0_0000_0001_0064, "R6"));
        hop(mk(1, 0, 0, 64, 64'd0, "R6"));
        hop(mk(1, 0, 0, 0, 64'd0, "R6"));
        flush();

        // R10: chain select has no effect in the direct geometry
        dop(mk(0, 1, 1, 50, 64'h0505_0505_0505_0505, "R10"));
        dop(mk(1, 0, 1, 50, 64'd0, "R10"));
        dop(mk(1, 0, 0, 50, 64'd0, "R10"));
        dop(mk(1, 0, 1, 50, 64'd0, "R10"));
        flush();

        // R8: hybrid direct words
        for (int i = 0; i < NSEG_H; i++) hop(mk(0, 1, 0, i, pat(i, 8), "R7"));
        for (int i = NSEG_H - 1; i >= 0; i--) hop(mk(1, 0, 0, i, 64'd0, "R8"));
        flush();

        // R9: load chain of segment 5, read it twice over
        for (int k = 0; k < CHW; k++) hop(mk(0, 1, 1, 5, pat(k, 9), "R9"));
        for (int k = 0; k < 2 * CHW; k++) hop(mk(1, 0, 1, 5, 64'd0, "R9"));
        hop(mk(1, 0, 0, 5, 64'd0, "R9"));
        hop(mk(1, 0, 1, 6, 64'd0, "R9"));
        hop(mk(1, 1, 1, 5, 64'h9999_0000_0000_0009, "R9"));
        for (int k = 0; k < CHW; k++) hop(mk(1, 0, 1, 5, 64'd0, "R9"));
        flush();
        flush();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule